// File: doc/BRIEF.md
# Bit-Reversed Binary Rate Multiplier

The block passes a programmable fraction M/2^N of its clock cycles. An N-bit counter runs freely and advances once per cycle. Each count value is compared against a latched rate value M, and the result goes out as a registered one-cycle pass enable. Downstream logic uses this enable to keep M out of every 2^N input cycles and drop the rest.

A mode input selects the order in which counter bits reach the comparator. In direct order the passed cycles form one burst at the start of each period. In spread order the counter is bit-reversed before the compare, so the least significant counter bit weighs most. The passed cycles then fall evenly across the period. Both the rate and the mode are captured only when the counter wraps, so every period runs under a single setting.

Top module: `rm_rate_mult`

## Requirements
- R1: While reset is low, `pass_o` is 0. Reset clears the counter, the latched rate and the latched mode (direct), so nothing passes during the first 2^N cycles after reset is released.
- R2: The counter advances by one on every clock cycle and wraps modulo 2^N. `pass_o` is registered and rises on the clock edge that follows the count it belongs to. With M=1 in direct mode it is high for exactly one cycle per period.
- R3: In direct mode (latched mode bit 0), the cycle for count c passes when c < M, so the passed cycles are the first M cycles of the period.
- R4: In spread mode (latched mode bit 1), the cycle for count c passes when the bit-reversal of c is less than M. Counter bit 0 drives comparator bit N-1, counter bit 1 drives comparator bit N-2, and so on.
- R5: For any M from 0 to 2^N-1, exactly M cycles pass in each 2^N-cycle period, in both modes.
- R6: `rate_i` and `spread_i` are sampled only on the edge where the counter goes from 2^N-1 to 0. Changes at any other time have no effect on the current period's output.
- R7: M=0 passes no cycle. M=2^N-1 passes every cycle except the one for count 2^N-1, in both modes.
- R8: In spread mode, exactly ceil(M/2) cycles pass in the first half of each period (counts below 2^(N-1)). When M ≤ 2^(N-1), no two consecutive cycles pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every cycle is a candidate for passing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_i | input | CNT_W | Rate value M, latched at the counter wrap |
| spread_i | input | 1 | Mode select: 0 direct order, 1 bit-reversed order; latched at the counter wrap |
| pass_o | output | 1 | Registered one-cycle pass enable |

## Verification
The assertions check the following on every cycle:
- the counter steps by one;
- the latched rate and mode hold steady except at the wrap;
- a zero rate passes nothing;
- in direct mode, once a cycle is blocked the rest of the period stays blocked;
- in spread mode at half rate or below, no two passes are adjacent.

Only the bench's scenarios can show the following:
- the exact position of every pass for a given count, compared against the bit-reversed ordering;
- the per-period total of M;
- the ceil(M/2) split between the two halves of the period;
- that a rate or mode change in mid-period leaves the running period unchanged.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic {
    RM_DIRECT = 1'b0,
    RM_SPREAD = 1'b1
  } rm_mode_e;
endpackage

// File: rtl/rm_counter.sv
module rm_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rm_rate_latch.sv
module rm_rate_latch
  import rm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] rate_i,
  input  logic             spread_i,
  output logic [CNT_W-1:0] rate_o,
  output rm_mode_e         mode_o
);
  logic [CNT_W-1:0] rate_q, rate_d;
  rm_mode_e         mode_q, mode_d;

  always_comb begin
    rate_d = rate_q;
    mode_d = mode_q;
    if (load_i) begin
      rate_d = rate_i;
      mode_d = spread_i ? RM_SPREAD : RM_DIRECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      mode_q <= RM_DIRECT;
    end else begin
      rate_q <= rate_d;
      mode_q <= mode_d;
    end
  end

  assign rate_o = rate_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/rm_compare.sv
module rm_compare
  import rm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] rate_i,
  input  rm_mode_e         mode_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_rev;
  logic [CNT_W-1:0] cmp_val;

  for (genvar b = 0; b < CNT_W; b++) begin : g_rev
    assign cnt_rev[CNT_W-1-b] = cnt_i[b];
  end

  always_comb begin
    cmp_val = (mode_i == RM_SPREAD) ? cnt_rev : cnt_i;
    hit_o   = (cmp_val < rate_i);
  end
endmodule

// File: rtl/rm_rate_mult.sv
module rm_rate_mult
  import rm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rate_i,
  input  logic             spread_i,
  output logic             pass_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic [CNT_W-1:0] rate_q;
  rm_mode_e         mode_q;
  logic             spread_q;
  logic             hit;
  logic             pass_d;
  logic             pass_q;

  rm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt_q),
    .wrap_o(wrap)
  );

  rm_rate_latch #(.CNT_W(CNT_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (wrap),
    .rate_i  (rate_i),
    .spread_i(spread_i),
    .rate_o  (rate_q),
    .mode_o  (mode_q)
  );

  rm_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i (cnt_q),
    .rate_i(rate_q),
    .mode_i(mode_q),
    .hit_o (hit)
  );

  assign spread_q = (mode_q == RM_SPREAD);

  always_comb begin
    pass_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
    end
  end

  assign pass_o = pass_q;
endmodule

// File: rtl/rm_rate_mult_chk.sv
module rm_rate_mult_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rate_q,
  input logic             spread_q,
  input logic             pass_o
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!pass_o);
    end
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($stable(rate_q) && $stable(spread_q)));

  a_r7_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |=> !pass_o);

  a_r3_blocked_to_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!spread_q && !pass_o && cnt_q != '0) |=> !pass_o);

  a_r8_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_q && rate_q <= HALF && pass_o && cnt_q != '0) |=> !pass_o);
endmodule

bind rm_rate_mult rm_rate_mult_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_q   (cnt_q),
  .rate_q  (rate_q),
  .spread_q(spread_q),
  .pass_o  (pass_o)
);

// File: tb/rm_rate_mult_test.sv
module rm_rate_mult_test;
  localparam int W = 5;
  localparam int P = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] rate_i;
  logic         spread_i;
  logic         pass_o;

  always #5 clk = ~clk;

  rm_rate_mult #(.CNT_W(W)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate_i  (rate_i),
    .spread_i(spread_i),
    .pass_o  (pass_o)
  );

  typedef struct {
    logic  exp;
    int    idx;
    int    m;
    logic  sp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    mon_en = 0;
  bit    ended  = 0;
  int    cur_m  = 0;
  logic  cur_sp = 1'b0;
  int    ones   = 0;
  int    half1  = 0;

  function automatic int rev(input int c);
    int r = 0;
    for (int b = 0; b < W; b++) if (c[b]) r = r | (1 << (W - 1 - b));
    return r;
  endfunction

  function automatic logic model(input int c, input int m, input logic sp);
    return sp ? (rev(c) < m) : (c < m);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (q.size() == 0) begin
        check("R2 queue underrun", 0, 1);
      end else begin
        item_t it;
        it = q.pop_front();
        check($sformatf("%s cnt=%0d m=%0d sp=%0d", it.tag, it.idx, it.m, it.sp),
              int'(pass_o), int'(it.exp));
        ones += int'(pass_o);
        if (it.idx < P / 2) half1 += int'(pass_o);
        if (it.idx == P - 1) begin
          check($sformatf("R5 period total m=%0d sp=%0d", it.m, it.sp), ones, it.m);
          if (it.sp) check($sformatf("R8 first-half total m=%0d", it.m), half1, (it.m + 1) / 2);
          ones  = 0;
          half1 = 0;
        end
      end
    end
  end

  task automatic period(input int nm, input logic nsp, input bit glitch);
    string tag;
    if (glitch) tag = "R6";
    else if (cur_m == 0 && !cur_sp && nm == 20) tag = "R1";
    else if (cur_m == 0 || cur_m == P - 1) tag = "R7";
    else if (cur_m == 1 && !cur_sp) tag = "R2";
    else tag = cur_sp ? "R4" : "R3";
    for (int i = 0; i < P; i++) begin
      item_t it;
      it.exp = model(i, cur_m, cur_sp);
      it.idx = i;
      it.m   = cur_m;
      it.sp  = cur_sp;
      it.tag = tag;
      q.push_back(it);
    end
    rate_i   = W'(nm);
    spread_i = nsp;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (glitch && i == 8) begin
        rate_i   = ~W'(nm);
        spread_i = ~nsp;
      end
      if (glitch && i == 20) begin
        rate_i   = W'(nm);
        spread_i = nsp;
      end
    end
    cur_m  = nm;
    cur_sp = nsp;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    rate_i   = W'(20);
    spread_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pass_o in reset", int'(pass_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    mon_en = 1;
    // period after reset runs with rate 0 although rate_i is 20 (R1)
    period(20, 1'b0, 1'b0);
    period(13, 1'b1, 1'b1);  // direct 20, disturbed inputs mid-period
    period(0,  1'b1, 1'b0);  // spread 13
    period(31, 1'b1, 1'b0);  // spread 0
    period(31, 1'b0, 1'b0);  // spread 31
    period(1,  1'b0, 1'b0);  // direct 31
    period(16, 1'b1, 1'b0);  // direct 1
    period(7,  1'b1, 1'b0);  // spread 16
    period(0,  1'b0, 1'b1);  // spread 7, disturbed inputs mid-period
    period(0,  1'b0, 1'b0);  // direct 0
    @(negedge clk);
    mon_en = 0;
    check("R2 leftover expected items", q.size(), 0);
    finish_run();
  end
endmodule